// File: doc/BRIEF.md
# Host Command Decoder and Address Multiplexer

This block sits between a host bus and an SDRAM command engine. The host uses a single shared 32-bit bus that carries both addresses and data, plus two control inputs. The first says whether the bus holds an address or a data word. The second says whether the cycle is write-type or read-type. Every clock is one host transfer, and the block runs in the SDRAM clock domain.

On an address transfer the block latches the word and decodes the two-bit opcode embedded in it. It then raises one request towards the engine and holds it until the engine acknowledges. The latched address is split into bank, row and column fields for the engine. The column is pre-formatted with the auto-precharge bit set.

Data transfers serve three purposes. A precharge command loads the controller configuration word. A read/write command opens a write-data window whose length comes from the burst field of that configuration. During read-type data transfers the bus is driven with words flagged valid by the engine.

Top module: `hostbus_cmd_front`

## Requirements
- R1: After reset no request is raised, `wr_valid` and `cfg_load` are 0, `ctrl_cfg` is 0, and the bus is released (high impedance) while the host does not drive it.
- R2: Transfer kinds are encoded as follows:
  - `host_data_sel`=0 marks an address transfer and `host_data_sel`=1 marks a data transfer.
  - `host_wr`=1 marks a write-type transfer and `host_wr`=0 marks a read-type transfer.

  An address transfer accepted while nothing is pending raises exactly one request in the next cycle. The request is chosen by bus bits [29:28]:
  - 00 raises `req_rw`, and `req_write` copies `host_wr`.
  - 11 raises `req_refresh`.
  - 10 raises `req_precharge`.
  - 01 raises `req_mode`.
- R3: A raised request stays raised, with its bank, row and column outputs unchanged, until `eng_ack` is sampled high. It is cleared in the cycle after that.
- R4: An address transfer that arrives while a request is pending has no effect on the requests or the address fields. This includes an address transfer in the same cycle as `eng_ack`.
- R5: From the latched address:
  - `bank` is bus bit 21.
  - `row` is bus bits [20:10].
  - `sd_col` bits [7:0] are bus bits [9:2], `sd_col` bit 10 is 1 (auto-precharge), and `sd_col` bits [9:8] are 0.
- R6: For a mode-load request, the SDRAM mode value taken from bus bits [20:10] is presented on `row`.
- R7: The first data-write transfer after an accepted precharge address loads bus bits [27:0] into `ctrl_cfg` in the next cycle, with a one-cycle `cfg_load` pulse. Later data-writes leave `ctrl_cfg` unchanged.
- R8: After an accepted read/write address transfer of write type, the next N data-write transfers appear on `wr_data` one cycle later with `wr_valid`=1. N is `ctrl_cfg` bits [6:4] plus 1. Further data-writes give `wr_valid`=0.
- R9: A data-write transfer with no open write window (none opened, or opened by a read-type address) gives `wr_valid`=0.
- R10: During a data-read transfer with `rd_valid`=1 the bus carries `rd_data` in the same cycle. In every other cycle the block leaves the bus undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ad | inout | 32 | Shared host address/data bus |
| host_data_sel | input | 1 | 1: data transfer, 0: address transfer |
| host_wr | input | 1 | 1: write-type, 0: read-type |
| eng_ack | input | 1 | Engine accepts the pending request |
| req_rw | output | 1 | Read/write request pending |
| req_write | output | 1 | Pending read/write is a write |
| req_refresh | output | 1 | Auto-refresh request pending |
| req_precharge | output | 1 | Precharge request pending |
| req_mode | output | 1 | SDRAM mode-load request pending |
| bank | output | 1 | Bank select |
| row | output | 11 | Row address / mode value |
| sd_col | output | 11 | Column-phase SDRAM address |
| ctrl_cfg | output | 28 | Controller configuration word |
| cfg_load | output | 1 | Configuration loaded last cycle |
| wr_data | output | 32 | Write data beat |
| wr_valid | output | 1 | Write data beat valid |
| rd_data | input | 32 | Read word from engine |
| rd_valid | input | 1 | Read word valid |

## Verification
The acknowledge of a pending request and a fresh address transfer can fall in the same clock. The block must treat that address as still blocked. The bench forces this by raising `eng_ack` in the very cycle it presents a new address with a different opcode and row. It then judges the outcome one and two cycles later: no request may be raised, and the row field must keep its old value. Write-data beats arriving while a request is still unacknowledged are a second overlap, and they are checked for being passed through with the request held stable.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
  typedef enum logic [1:0] {
    OP_RW      = 2'b00,
    OP_MODE    = 2'b01,
    OP_PRECHG  = 2'b10,
    OP_REFRESH = 2'b11
  } hbf_op_e;

  typedef enum logic [1:0] {
    XK_ADDR_RD = 2'b00,
    XK_ADDR_WR = 2'b01,
    XK_DATA_RD = 2'b10,
    XK_DATA_WR = 2'b11
  } hbf_kind_e;
endpackage

// File: rtl/hbf_classify.sv
module hbf_classify
  import hbf_pkg::*;
(
  input  logic data_sel,
  input  logic wr,
  output logic addr_cyc,
  output logic addr_wr_cyc,
  output logic data_wr_cyc,
  output logic data_rd_cyc
);
  hbf_kind_e kind;

  always_comb begin
    kind        = hbf_kind_e'({data_sel, wr});
    addr_cyc    = (kind == XK_ADDR_RD) || (kind == XK_ADDR_WR);
    addr_wr_cyc = (kind == XK_ADDR_WR);
    data_wr_cyc = (kind == XK_DATA_WR);
    data_rd_cyc = (kind == XK_DATA_RD);
  end
endmodule

// File: rtl/hbf_addr_split.sv
module hbf_addr_split #(
  parameter int BUS_W    = 32,
  parameter int OP_LSB   = 28,
  parameter int BANK_BIT = 21,
  parameter int ROW_LSB  = 10,
  parameter int ROW_W    = 11,
  parameter int COL_LSB  = 2,
  parameter int COL_W    = 8,
  parameter int SD_AW    = 11,
  parameter int AP_BIT   = 10
) (
  input  logic [BUS_W-1:0] bus_word,
  output logic [1:0]       f_op,
  output logic             f_bank,
  output logic [ROW_W-1:0] f_row,
  output logic [COL_W-1:0] f_col,
  input  logic [COL_W-1:0] lat_col,
  output logic [SD_AW-1:0] sd_col
);
  wire unused_bus_par = ^bus_word;

  assign f_op   = bus_word[OP_LSB +: 2];
  assign f_bank = bus_word[BANK_BIT];
  assign f_row  = bus_word[ROW_LSB +: ROW_W];
  assign f_col  = bus_word[COL_LSB +: COL_W];

  for (genvar i = 0; i < SD_AW; i++) begin : g_colbit
    if (i < COL_W) begin : g_col
      assign sd_col[i] = lat_col[i];
    end else if (i == AP_BIT) begin : g_ap
      assign sd_col[i] = 1'b1;
    end else begin : g_zero
      assign sd_col[i] = 1'b0;
    end
  end
endmodule

// File: rtl/hbf_req_latch.sv
module hbf_req_latch
  import hbf_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_cyc,
  input  logic             host_wr,
  input  logic [1:0]       f_op,
  input  logic             f_bank,
  input  logic [ROW_W-1:0] f_row,
  input  logic [COL_W-1:0] f_col,
  input  logic             eng_ack,
  output logic             accept,
  output logic             req_rw,
  output logic             req_write,
  output logic             req_refresh,
  output logic             req_precharge,
  output logic             req_mode,
  output logic             bank_q,
  output logic [ROW_W-1:0] row_q,
  output logic [COL_W-1:0] col_q
);
  logic             pend_q, pend_d;
  hbf_op_e          op_q, op_d;
  logic             wr_q, wr_d;
  logic             bank_d;
  logic [ROW_W-1:0] row_d;
  logic [COL_W-1:0] col_d;
  logic             load_en;

  assign accept  = addr_cyc && !pend_q;
  assign load_en = accept;

  always_comb begin
    pend_d = pend_q;
    op_d   = op_q;
    wr_d   = wr_q;
    bank_d = bank_q;
    row_d  = row_q;
    col_d  = col_q;
    if (pend_q && eng_ack) begin
      pend_d = 1'b0;
    end else if (load_en) begin
      pend_d = 1'b1;
      op_d   = hbf_op_e'(f_op);
      wr_d   = host_wr;
      bank_d = f_bank;
      row_d  = f_row;
      col_d  = f_col;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      op_q   <= OP_RW;
      wr_q   <= 1'b0;
      bank_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      pend_q <= pend_d;
      op_q   <= op_d;
      wr_q   <= wr_d;
      bank_q <= bank_d;
      row_q  <= row_d;
      col_q  <= col_d;
    end
  end

  always_comb begin
    req_rw        = pend_q && (op_q == OP_RW);
    req_write     = req_rw && wr_q;
    req_refresh   = pend_q && (op_q == OP_REFRESH);
    req_precharge = pend_q && (op_q == OP_PRECHG);
    req_mode      = pend_q && (op_q == OP_MODE);
  end
endmodule

// File: rtl/hbf_data_path.sv
module hbf_data_path
  import hbf_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int CFG_W  = 28,
  parameter int BL_LSB = 4,
  parameter int BL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [1:0]       accept_op,
  input  logic             accept_wr,
  input  logic             data_wr_cyc,
  input  logic             data_rd_cyc,
  input  logic [BUS_W-1:0] bus_in,
  input  logic             rd_valid,
  input  logic [BUS_W-1:0] rd_data,
  output logic [CFG_W-1:0] ctrl_cfg,
  output logic             cfg_load,
  output logic [BUS_W-1:0] wr_data,
  output logic             wr_valid,
  output logic             drive_en,
  output logic [BUS_W-1:0] drive_data
);
  localparam int BEAT_W = BL_W + 1;

  logic [CFG_W-1:0]  cfg_d;
  logic              cfg_load_d;
  logic              cfg_arm_q, cfg_arm_d;
  logic [BEAT_W-1:0] left_q, left_d;
  logic [BEAT_W-1:0] burst_len;
  logic [BUS_W-1:0]  wr_data_d;
  logic              wr_valid_d;
  logic              beat_en;

  assign burst_len = {1'b0, ctrl_cfg[BL_LSB +: BL_W]} + BEAT_W'(1);
  assign beat_en   = data_wr_cyc && (left_q != '0);

  always_comb begin
    cfg_d      = ctrl_cfg;
    cfg_load_d = 1'b0;
    cfg_arm_d  = cfg_arm_q;
    left_d     = left_q;
    wr_data_d  = wr_data;
    wr_valid_d = 1'b0;
    if (accept) begin
      cfg_arm_d = (hbf_op_e'(accept_op) == OP_PRECHG);
      left_d    = ((hbf_op_e'(accept_op) == OP_RW) && accept_wr) ? burst_len : '0;
    end else if (data_wr_cyc) begin
      if (cfg_arm_q) begin
        cfg_d      = bus_in[CFG_W-1:0];
        cfg_load_d = 1'b1;
        cfg_arm_d  = 1'b0;
      end
      if (beat_en) begin
        left_d     = left_q - BEAT_W'(1);
        wr_data_d  = bus_in;
        wr_valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_cfg  <= '0;
      cfg_load  <= 1'b0;
      cfg_arm_q <= 1'b0;
      left_q    <= '0;
      wr_data   <= '0;
      wr_valid  <= 1'b0;
    end else begin
      ctrl_cfg  <= cfg_d;
      cfg_load  <= cfg_load_d;
      cfg_arm_q <= cfg_arm_d;
      left_q    <= left_d;
      wr_valid  <= wr_valid_d;
      if (beat_en) begin
        wr_data <= wr_data_d;
      end
    end
  end

  assign drive_en   = data_rd_cyc && rd_valid;
  assign drive_data = rd_data;
endmodule

// File: rtl/hostbus_cmd_front.sv
module hostbus_cmd_front #(
  parameter int BUS_W    = 32,
  parameter int OP_LSB   = 28,
  parameter int BANK_BIT = 21,
  parameter int ROW_LSB  = 10,
  parameter int ROW_W    = 11,
  parameter int COL_LSB  = 2,
  parameter int COL_W    = 8,
  parameter int SD_AW    = 11,
  parameter int AP_BIT   = 10,
  parameter int CFG_W    = 28,
  parameter int BL_LSB   = 4,
  parameter int BL_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  inout  wire  [BUS_W-1:0] host_ad,
  input  logic             host_data_sel,
  input  logic             host_wr,
  input  logic             eng_ack,
  output logic             req_rw,
  output logic             req_write,
  output logic             req_refresh,
  output logic             req_precharge,
  output logic             req_mode,
  output logic             bank,
  output logic [ROW_W-1:0] row,
  output logic [SD_AW-1:0] sd_col,
  output logic [CFG_W-1:0] ctrl_cfg,
  output logic             cfg_load,
  output logic [BUS_W-1:0] wr_data,
  output logic             wr_valid,
  input  logic [BUS_W-1:0] rd_data,
  input  logic             rd_valid
);
  logic             addr_cyc, addr_wr_cyc, data_wr_cyc, data_rd_cyc;
  logic [1:0]       f_op;
  logic             f_bank;
  logic [ROW_W-1:0] f_row;
  logic [COL_W-1:0] f_col, col_q;
  logic             accept;
  logic             drive_en;
  logic [BUS_W-1:0] drive_data;
  logic [BUS_W-1:0] bus_in;

  assign bus_in  = host_ad;
  assign host_ad = drive_en ? drive_data : {BUS_W{1'bz}};

  hbf_classify u_classify (
    .data_sel    (host_data_sel),
    .wr          (host_wr),
    .addr_cyc    (addr_cyc),
    .addr_wr_cyc (addr_wr_cyc),
    .data_wr_cyc (data_wr_cyc),
    .data_rd_cyc (data_rd_cyc)
  );

  hbf_addr_split #(
    .BUS_W(BUS_W), .OP_LSB(OP_LSB), .BANK_BIT(BANK_BIT), .ROW_LSB(ROW_LSB),
    .ROW_W(ROW_W), .COL_LSB(COL_LSB), .COL_W(COL_W), .SD_AW(SD_AW), .AP_BIT(AP_BIT)
  ) u_split (
    .bus_word (bus_in),
    .f_op     (f_op),
    .f_bank   (f_bank),
    .f_row    (f_row),
    .f_col    (f_col),
    .lat_col  (col_q),
    .sd_col   (sd_col)
  );

  hbf_req_latch #(.ROW_W(ROW_W), .COL_W(COL_W)) u_req (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr_cyc      (addr_cyc),
    .host_wr       (addr_wr_cyc),
    .f_op          (f_op),
    .f_bank        (f_bank),
    .f_row         (f_row),
    .f_col         (f_col),
    .eng_ack       (eng_ack),
    .accept        (accept),
    .req_rw        (req_rw),
    .req_write     (req_write),
    .req_refresh   (req_refresh),
    .req_precharge (req_precharge),
    .req_mode      (req_mode),
    .bank_q        (bank),
    .row_q         (row),
    .col_q         (col_q)
  );

  hbf_data_path #(
    .BUS_W(BUS_W), .CFG_W(CFG_W), .BL_LSB(BL_LSB), .BL_W(BL_W)
  ) u_data (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .accept_op   (f_op),
    .accept_wr   (addr_wr_cyc),
    .data_wr_cyc (data_wr_cyc),
    .data_rd_cyc (data_rd_cyc),
    .bus_in      (bus_in),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .ctrl_cfg    (ctrl_cfg),
    .cfg_load    (cfg_load),
    .wr_data     (wr_data),
    .wr_valid    (wr_valid),
    .drive_en    (drive_en),
    .drive_data  (drive_data)
  );
endmodule

// File: rtl/hbf_checker.sv
module hbf_checker #(
  parameter int BUS_W = 32,
  parameter int ROW_W = 11,
  parameter int SD_AW = 11,
  parameter int CFG_W = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BUS_W-1:0] host_ad,
  input logic             host_data_sel,
  input logic             host_wr,
  input logic             eng_ack,
  input logic             req_rw,
  input logic             req_refresh,
  input logic             req_precharge,
  input logic             req_mode,
  input logic             bank,
  input logic [ROW_W-1:0] row,
  input logic [SD_AW-1:0] sd_col,
  input logic [CFG_W-1:0] ctrl_cfg,
  input logic             cfg_load,
  input logic [BUS_W-1:0] wr_data,
  input logic             wr_valid,
  input logic [BUS_W-1:0] rd_data,
  input logic             rd_valid
);
  logic [3:0] reqs;
  logic       pend;
  assign reqs = {req_rw, req_refresh, req_precharge, req_mode};
  assign pend = |reqs;

  // R2
  one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reqs));

  // R3
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !eng_ack) |=> (reqs == $past(reqs)) && $stable(row) && $stable(bank) && $stable(sd_col));

  // R3
  clear_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && eng_ack) |=> !pend);

  // R4
  blocked_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !host_data_sel) |=> $stable(row));

  // R7
  cfg_from_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |-> (ctrl_cfg == $past(host_ad[CFG_W-1:0])));

  // R8
  beat_from_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ($past(host_data_sel && host_wr) && wr_data == $past(host_ad)));

  // R10
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_data_sel && !host_wr && rd_valid) |-> (host_ad == rd_data));
endmodule

bind hostbus_cmd_front hbf_checker #(
  .BUS_W(BUS_W), .ROW_W(ROW_W), .SD_AW(SD_AW), .CFG_W(CFG_W)
) u_hbf_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_ad       (host_ad),
  .host_data_sel (host_data_sel),
  .host_wr       (host_wr),
  .eng_ack       (eng_ack),
  .req_rw        (req_rw),
  .req_refresh   (req_refresh),
  .req_precharge (req_precharge),
  .req_mode      (req_mode),
  .bank          (bank),
  .row           (row),
  .sd_col        (sd_col),
  .ctrl_cfg      (ctrl_cfg),
  .cfg_load      (cfg_load),
  .wr_data       (wr_data),
  .wr_valid      (wr_valid),
  .rd_data       (rd_data),
  .rd_valid      (rd_valid)
);

// File: tb/hostbus_cmd_front_bench.sv
`timescale 1ns/1ps
module hostbus_cmd_front_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  wire  [31:0] host_ad;
  logic        host_data_sel, host_wr, eng_ack;
  logic        req_rw, req_write, req_refresh, req_precharge, req_mode;
  logic        bank;
  logic [10:0] row, sd_col;
  logic [27:0] ctrl_cfg;
  logic        cfg_load;
  logic [31:0] wr_data;
  logic        wr_valid;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        tb_en;
  logic [31:0] tb_val;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  assign host_ad = tb_en ? tb_val : 32'bz;

  hostbus_cmd_front u_hostbus_cmd_front (
    .clk(clk), .rst_n(rst_n), .host_ad(host_ad),
    .host_data_sel(host_data_sel), .host_wr(host_wr), .eng_ack(eng_ack),
    .req_rw(req_rw), .req_write(req_write), .req_refresh(req_refresh),
    .req_precharge(req_precharge), .req_mode(req_mode),
    .bank(bank), .row(row), .sd_col(sd_col),
    .ctrl_cfg(ctrl_cfg), .cfg_load(cfg_load),
    .wr_data(wr_data), .wr_valid(wr_valid),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] reqs();
    return {req_rw, req_write, req_refresh, req_precharge, req_mode};
  endfunction

  // one host transfer; called at a falling edge, returns at the next falling edge
  task automatic xfer(input logic sel, input logic wr, input logic [31:0] val, input logic ack);
    host_data_sel = sel;
    host_wr       = wr;
    tb_en         = !(sel && !wr);
    tb_val        = val;
    eng_ack       = ack;
    @(posedge clk);
    @(negedge clk);
    host_data_sel = 1'b1;
    host_wr       = 1'b0;
    tb_en         = 1'b0;
    eng_ack       = 1'b0;
  endtask

  function automatic logic [31:0] addr_word(input logic [1:0] op, input logic bk,
                                             input logic [10:0] r, input logic [7:0] c);
    return {2'b00, op, 6'b0, bk, r, c, 2'b00};
  endfunction

  task automatic t_reset();
    check("R1 requests", {27'b0, reqs()}, 32'h0);
    check("R1 wr_valid", {31'b0, wr_valid}, 32'h0);
    check("R1 cfg_load", {31'b0, cfg_load}, 32'h0);
    check("R1 ctrl_cfg", {4'b0, ctrl_cfg}, 32'h0);
    check("R1 bus released", host_ad, 32'hzzzzzzzz);
  endtask

  task automatic t_precharge_cfg();
    xfer(1'b0, 1'b1, addr_word(2'b10, 1'b0, 11'h0, 8'h0), 1'b0);
    check("R2 precharge request", {27'b0, reqs()}, 32'b00010);
    xfer(1'b1, 1'b1, 32'hF0AB_CD35, 1'b0);
    check("R7 cfg_load pulse", {31'b0, cfg_load}, 32'h1);
    check("R7 cfg value", {4'b0, ctrl_cfg}, 32'h00AB_CD35);
    check("R9 cfg word is not a beat", {31'b0, wr_valid}, 32'h0);
    xfer(1'b1, 1'b1, 32'h0123_4567, 1'b1);
    check("R7 later data-write keeps cfg", {4'b0, ctrl_cfg}, 32'h00AB_CD35);
    check("R7 no second pulse", {31'b0, cfg_load}, 32'h0);
    check("R3 cleared after ack", {27'b0, reqs()}, 32'h0);
  endtask

  task automatic t_write_burst();
    // burst field bits [6:4] = 3 -> 4 beats
    xfer(1'b0, 1'b1, addr_word(2'b00, 1'b1, 11'h5A3, 8'hC7), 1'b0);
    check("R2 write request", {27'b0, reqs()}, 32'b11000);
    check("R5 bank", {31'b0, bank}, 32'h1);
    check("R5 row", {21'b0, row}, 32'h5A3);
    check("R5 column phase", {21'b0, sd_col}, 32'h4C7);
    for (int i = 0; i < 5; i++) begin
      xfer(1'b1, 1'b1, 32'hD000_0000 + i, 1'b0);
      if (i < 4) begin
        check("R8 beat valid", {31'b0, wr_valid}, 32'h1);
        check("R8 beat data", wr_data, 32'hD000_0000 + i);
      end else begin
        check("R8 beat past burst end", {31'b0, wr_valid}, 32'h0);
      end
    end
    check("R3 held during beats", {27'b0, reqs()}, 32'b11000);
    check("R3 row held", {21'b0, row}, 32'h5A3);
    xfer(1'b1, 1'b0, 32'h0, 1'b1);
    check("R3 cleared after ack", {27'b0, reqs()}, 32'h0);
  endtask

  task automatic t_pending_ignore();
    xfer(1'b0, 1'b0, addr_word(2'b11, 1'b0, 11'h111, 8'h11), 1'b0);
    check("R2 refresh request", {27'b0, reqs()}, 32'b00100);
    xfer(1'b0, 1'b1, addr_word(2'b01, 1'b1, 11'h222, 8'h22), 1'b0);
    check("R4 kind unchanged", {27'b0, reqs()}, 32'b00100);
    check("R4 row unchanged", {21'b0, row}, 32'h111);
    check("R4 bank unchanged", {31'b0, bank}, 32'h0);
    xfer(1'b0, 1'b1, addr_word(2'b10, 1'b1, 11'h333, 8'h33), 1'b1);
    check("R4 address with ack not taken", {27'b0, reqs()}, 32'h0);
    check("R4 row after ack-cycle address", {21'b0, row}, 32'h111);
    xfer(1'b1, 1'b0, 32'h0, 1'b0);
    check("R4 still no request", {27'b0, reqs()}, 32'h0);
    xfer(1'b1, 1'b1, 32'h0FFF_FFFF, 1'b0);
    check("R4 no cfg load from blocked precharge", {31'b0, cfg_load}, 32'h0);
  endtask

  task automatic t_mode_load();
    xfer(1'b0, 1'b1, addr_word(2'b01, 1'b0, 11'h233, 8'h00), 1'b0);
    check("R2 mode request", {27'b0, reqs()}, 32'b00001);
    check("R6 mode value on row", {21'b0, row}, 32'h233);
    xfer(1'b1, 1'b0, 32'h0, 1'b1);
  endtask

  task automatic t_stray_data();
    xfer(1'b1, 1'b1, 32'hBAD0_0001, 1'b0);
    check("R9 data-write without window", {31'b0, wr_valid}, 32'h0);
    xfer(1'b0, 1'b0, addr_word(2'b00, 1'b0, 11'h7FF, 8'hFF), 1'b0);
    check("R2 read request", {27'b0, reqs()}, 32'b10000);
    check("R5 column max", {21'b0, sd_col}, 32'h4FF);
    xfer(1'b1, 1'b1, 32'hBAD0_0002, 1'b0);
    check("R9 read address opens no window", {31'b0, wr_valid}, 32'h0);
    xfer(1'b1, 1'b0, 32'h0, 1'b1);
  endtask

  task automatic t_read_drive();
    rd_data  = 32'hCAFE_F00D;
    rd_valid = 1'b1;
    host_data_sel = 1'b1; host_wr = 1'b0; tb_en = 1'b0;
    #1;
    check("R10 bus driven with read word", host_ad, 32'hCAFE_F00D);
    rd_valid = 1'b0;
    #1;
    check("R10 released without valid", host_ad, 32'hzzzzzzzz);
    rd_valid = 1'b1;
    host_wr = 1'b1; tb_val = 32'h1357_9BDF; tb_en = 1'b1;
    #1;
    check("R10 no drive in data-write", host_ad, 32'h1357_9BDF);
    @(posedge clk);
    @(negedge clk);
    rd_valid = 1'b0; tb_en = 1'b0; host_wr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    host_data_sel = 1'b1; host_wr = 1'b0; eng_ack = 1'b0;
    tb_en = 1'b0; tb_val = '0; rd_data = '0; rd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_precharge_cfg();
    t_write_burst();
    t_pending_ignore();
    t_mode_load();
    t_stray_data();
    t_read_drive();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule